// File: doc/BRIEF.md
# Exception Mask Register Access Unit

This unit holds the four process-state exception mask bits: debug (D), SError (A), IRQ (I) and FIQ (F). It decodes system-register move requests that touch them. These are a full-register read, a full-register write, and two immediate forms that set or clear selected bits. Each request is checked against the current exception level and the feature, host-mode and trap-routing controls. The unit then returns read data, a trap request with a target level and syndrome class, or an undefined-instruction indication.

The stored masks also drive per-source mask outputs for a downstream exception arbiter. The debug mask only applies to debug exceptions that target the current level. Instruction fetch, the register file and trap entry are outside the unit. They connect through a single-cycle request port and a registered response port. A response appears on the cycle after the request. Any mask update takes effect on that same edge.

Top module: `excmask_unit`

## Requirements
- R1: While reset is asserted and after it is released, all four mask bits read 1 (`daif_o` = 4'b1111 as {D,A,I,F}) and `rsp_valid_o` is low.
- R2: A permitted register read returns 64 bits that are zero except bits 9:6, which hold D, A, I, F (bit 9 = D). The read also raises `rsp_rd_we_o`.
- R3: A permitted register write loads D, A, I, F from bits 9, 8, 7, 6 of `req_wdata_i`. All other operand bits have no effect.
- R4: The immediate value is carried in the CRm field, with bit 3 = D, bit 2 = A, bit 1 = I and bit 0 = F. With op2 = 3'b110 the selected bits are set. With op2 = 3'b111 they are cleared. Unselected bits keep their value.
- R5: A request is recognised only in two cases. The register form needs op0 = 2'b11, op1 = 3'b011, CRn = 4'b0100, CRm = 4'b0010 and op2 = 3'b001, with `req_is_read_i` choosing read or write. The immediate forms need op0 = 2'b00, op1 = 3'b011, CRn = 4'b0100 and op2 = 3'b110 or 3'b111. Any other request gives no response and changes nothing.
- R6: At EL1, EL2 and EL3 (`cur_el_i` = 1, 2, 3) a recognised access never traps.
- R7: At EL0 a recognised access traps when `el0_host_i` is 1 or `uma_en_i` is 0. The target is EL2 when `el2_en_i` and `tge_i` are both 1, and EL1 otherwise. `trap_ec_o` is 6'h18.
- R8: With `feat_i` low, a recognised access raises `undef_o` and neither traps nor reads nor writes.
- R9: A trapped or undefined access leaves the masks unchanged and keeps `rsp_rd_we_o` low.
- R10: `serr_mask_o`, `irq_mask_o` and `fiq_mask_o` equal the stored A, I and F bits.
- R11: `dbg_mask_o` is D when `dbg_target_el_i` equals `cur_el_i`, and 0 when the debug target level is higher.
- R12: The response for a request held in cycle n appears in cycle n+1. `rsp_valid_o` is low in cycles that follow no recognised request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op0_i | input | 2 | op0 field |
| req_op1_i | input | 3 | op1 field |
| req_crn_i | input | 4 | CRn field |
| req_crm_i | input | 4 | CRm field, immediate value for set/clear |
| req_op2_i | input | 3 | op2 field |
| req_is_read_i | input | 1 | 1 = register read, 0 = register write |
| req_wdata_i | input | 64 | Source operand for register write |
| cur_el_i | input | 2 | Current exception level |
| feat_i | input | 1 | Mask register feature implemented |
| el0_host_i | input | 1 | EL0 runs in host mode |
| uma_en_i | input | 1 | User mask access enable |
| el2_en_i | input | 1 | EL2 enabled |
| tge_i | input | 1 | Trap-general control |
| dbg_target_el_i | input | 2 | Target level of pending debug exception |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 64 | Read data |
| rsp_rd_we_o | output | 1 | Write destination register |
| trap_o | output | 1 | Trap request |
| trap_el_o | output | 2 | Trap target level |
| trap_ec_o | output | 6 | Trap syndrome class |
| undef_o | output | 1 | Undefined-instruction indication |
| daif_o | output | 4 | Stored masks {D,A,I,F} |
| dbg_mask_o | output | 1 | Debug exception masked |
| serr_mask_o | output | 1 | SError masked |
| irq_mask_o | output | 1 | IRQ masked |
| fiq_mask_o | output | 1 | FIQ masked |

## Verification
The assertions watch several invariants on every cycle. Reserved read-data bits stay zero, and trap and undefined responses leave the masks frozen. EL1 to EL3 never trap, and the syndrome class and target level are always legal. A debug exception aimed at a higher level is never masked. Other properties are visible only in the bench scenarios: the bit-exact effect of writes and immediate set/clear, the EL2 versus EL1 routing under the host and trap-general combinations, and rejection of near-miss encodings. These scenarios are checked against a reference model in the bench.

// File: rtl/excmask_pkg.sv
package excmask_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned MASK_LSB = 6;
  localparam int unsigned NMASK    = 4;
  localparam int unsigned ECW      = 6;

  localparam logic [1:0] REG_OP0 = 2'b11;
  localparam logic [1:0] IMM_OP0 = 2'b00;
  localparam logic [2:0] ACC_OP1 = 3'b011;
  localparam logic [3:0] ACC_CRN = 4'b0100;
  localparam logic [3:0] REG_CRM = 4'b0010;
  localparam logic [2:0] REG_OP2 = 3'b001;
  localparam logic [2:0] SET_OP2 = 3'b110;
  localparam logic [2:0] CLR_OP2 = 3'b111;

  typedef logic [1:0] el_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_READ,
    ACC_WRITE,
    ACC_SET,
    ACC_CLR
  } acc_e;

  typedef struct packed {
    logic undef;
    logic trap;
    el_t  trap_el;
  } perm_t;
endpackage

// File: rtl/excmask_decode.sv
module excmask_decode
  import excmask_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       is_read_i,
  output acc_e       acc_o
);
  logic common_hit;
  logic reg_hit;
  logic imm_hit;

  assign common_hit = valid_i && (op1_i == ACC_OP1) && (crn_i == ACC_CRN);
  assign reg_hit    = common_hit && (op0_i == REG_OP0) && (crm_i == REG_CRM)
                      && (op2_i == REG_OP2);
  assign imm_hit    = common_hit && (op0_i == IMM_OP0);

  always_comb begin
    acc_o = ACC_NONE;
    if (reg_hit) begin
      acc_o = is_read_i ? ACC_READ : ACC_WRITE;
    end else if (imm_hit) begin
      unique case (op2_i)
        SET_OP2: acc_o = ACC_SET;
        CLR_OP2: acc_o = ACC_CLR;
        default: acc_o = ACC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/excmask_perm.sv
module excmask_perm
  import excmask_pkg::*;
(
  input  acc_e  acc_i,
  input  logic  feat_i,
  input  el_t   cur_el_i,
  input  logic  el0_host_i,
  input  logic  uma_en_i,
  input  logic  el2_en_i,
  input  logic  tge_i,
  output perm_t perm_o,
  output logic  allow_o
);
  logic hit;
  logic el0_block;

  assign hit       = (acc_i != ACC_NONE);
  assign el0_block = (cur_el_i == 2'd0) && (el0_host_i || !uma_en_i);

  always_comb begin
    perm_o = '0;
    if (hit) begin
      if (!feat_i) begin
        perm_o.undef = 1'b1;
      end else if (el0_block) begin
        perm_o.trap    = 1'b1;
        perm_o.trap_el = (el2_en_i && tge_i) ? 2'd2 : 2'd1;
      end
    end
  end

  assign allow_o = hit && !perm_o.undef && !perm_o.trap;
endmodule

// File: rtl/excmask_state.sv
module excmask_state
  import excmask_pkg::*;
#(
  parameter int unsigned W          = XLEN,
  parameter int unsigned LSB        = MASK_LSB,
  parameter int unsigned N          = NMASK,
  parameter logic [N-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  acc_e         acc_i,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] imm_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      mask_d[k] = mask_q[k];
      if (upd_i) begin
        unique case (acc_i)
          ACC_WRITE: mask_d[k] = wdata_i[LSB+k];
          ACC_SET:   mask_d[k] = mask_q[k] | imm_i[k];
          ACC_CLR:   mask_d[k] = mask_q[k] & ~imm_i[k];
          default:   mask_d[k] = mask_q[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RESET_VAL;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/excmask_route.sv
module excmask_route
  import excmask_pkg::*;
(
  input  logic [3:0] mask_i,
  input  el_t        cur_el_i,
  input  el_t        dbg_target_el_i,
  output logic       dbg_mask_o,
  output logic       serr_mask_o,
  output logic       irq_mask_o,
  output logic       fiq_mask_o
);
  // D only covers debug exceptions taken at the current level
  assign dbg_mask_o  = mask_i[3] && (dbg_target_el_i == cur_el_i);
  assign serr_mask_o = mask_i[2];
  assign irq_mask_o  = mask_i[1];
  assign fiq_mask_o  = mask_i[0];
endmodule

// File: rtl/excmask_unit.sv
module excmask_unit
  import excmask_pkg::*;
#(
  parameter int unsigned    DATA_W   = XLEN,
  parameter int unsigned    FIELD_LO = MASK_LSB,
  parameter logic [ECW-1:0] TRAP_EC  = 6'h18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op0_i,
  input  logic [2:0]        req_op1_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_op2_i,
  input  logic              req_is_read_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        cur_el_i,
  input  logic              feat_i,
  input  logic              el0_host_i,
  input  logic              uma_en_i,
  input  logic              el2_en_i,
  input  logic              tge_i,
  input  logic [1:0]        dbg_target_el_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_rd_we_o,
  output logic              trap_o,
  output logic [1:0]        trap_el_o,
  output logic [ECW-1:0]    trap_ec_o,
  output logic              undef_o,
  output logic [3:0]        daif_o,
  output logic              dbg_mask_o,
  output logic              serr_mask_o,
  output logic              irq_mask_o,
  output logic              fiq_mask_o
);
  localparam int unsigned N = NMASK;

  acc_e             acc;
  perm_t            perm;
  logic             allow;
  logic [N-1:0]     mask;
  logic [DATA_W-1:0] rdata_d;

  excmask_decode u_dec (
    .valid_i   (req_valid_i),
    .op0_i     (req_op0_i),
    .op1_i     (req_op1_i),
    .crn_i     (req_crn_i),
    .crm_i     (req_crm_i),
    .op2_i     (req_op2_i),
    .is_read_i (req_is_read_i),
    .acc_o     (acc)
  );

  excmask_perm u_perm (
    .acc_i      (acc),
    .feat_i     (feat_i),
    .cur_el_i   (cur_el_i),
    .el0_host_i (el0_host_i),
    .uma_en_i   (uma_en_i),
    .el2_en_i   (el2_en_i),
    .tge_i      (tge_i),
    .perm_o     (perm),
    .allow_o    (allow)
  );

  excmask_state #(
    .W   (DATA_W),
    .LSB (FIELD_LO),
    .N   (N)
  ) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (allow),
    .acc_i   (acc),
    .wdata_i (req_wdata_i),
    .imm_i   (req_crm_i[N-1:0]),
    .mask_o  (mask)
  );

  excmask_route u_route (
    .mask_i          (mask),
    .cur_el_i        (cur_el_i),
    .dbg_target_el_i (dbg_target_el_i),
    .dbg_mask_o      (dbg_mask_o),
    .serr_mask_o     (serr_mask_o),
    .irq_mask_o      (irq_mask_o),
    .fiq_mask_o      (fiq_mask_o)
  );

  always_comb begin
    rdata_d = '0;
    if (allow && (acc == ACC_READ)) rdata_d[FIELD_LO +: N] = mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_rd_we_o <= 1'b0;
      trap_o      <= 1'b0;
      trap_el_o   <= '0;
      trap_ec_o   <= '0;
      undef_o     <= 1'b0;
    end else begin
      rsp_valid_o <= (acc != ACC_NONE);
      rsp_rdata_o <= rdata_d;
      rsp_rd_we_o <= allow && (acc == ACC_READ);
      trap_o      <= perm.trap;
      trap_el_o   <= perm.trap_el;
      trap_ec_o   <= perm.trap ? TRAP_EC : '0;
      undef_o     <= perm.undef;
    end
  end

  assign daif_o = mask;
endmodule

// File: rtl/excmask_unit_chk.sv
module excmask_unit_chk #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned FIELD_LO = 6,
  parameter logic [5:0]  TRAP_EC  = 6'h18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        cur_el_i,
  input logic              feat_i,
  input logic [1:0]        dbg_target_el_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_rd_we_o,
  input logic              trap_o,
  input logic [1:0]        trap_el_o,
  input logic [5:0]        trap_ec_o,
  input logic              undef_o,
  input logic [3:0]        daif_o,
  input logic              dbg_mask_o
);
  localparam logic [DATA_W-1:0] FIELD = {{(DATA_W-4){1'b0}}, 4'hF} << FIELD_LO;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_rdata_o & ~FIELD) == '0); // R2
  AST_HOLD_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (trap_o || undef_o) |-> daif_o == $past(daif_o)); // R9
  AST_NO_WE_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o || undef_o) |-> !rsp_rd_we_o); // R9
  AST_HIGH_EL_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && ($past(cur_el_i) != 2'd0) |-> !trap_o); // R6
  AST_TRAP_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_ec_o == TRAP_EC) && (trap_el_o == 2'd1 || trap_el_o == 2'd2)); // R7
  AST_NOFEAT_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !$past(feat_i) |-> undef_o && !trap_o); // R8
  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i)); // R12
  AST_DBG_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_target_el_i > cur_el_i) |-> !dbg_mask_o); // R11
endmodule

bind excmask_unit excmask_unit_chk #(
  .DATA_W   (DATA_W),
  .FIELD_LO (FIELD_LO),
  .TRAP_EC  (TRAP_EC)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .cur_el_i        (cur_el_i),
  .feat_i          (feat_i),
  .dbg_target_el_i (dbg_target_el_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_rdata_o     (rsp_rdata_o),
  .rsp_rd_we_o     (rsp_rd_we_o),
  .trap_o          (trap_o),
  .trap_el_o       (trap_el_o),
  .trap_ec_o       (trap_ec_o),
  .undef_o         (undef_o),
  .daif_o          (daif_o),
  .dbg_mask_o      (dbg_mask_o)
);

// File: tb/excmask_unit_tb_top.sv
module excmask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v, rd, feat, host, uma, e2, tge;
  logic [1:0]  op0, el, dtgt;
  logic [2:0]  op1, op2;
  logic [3:0]  crn, crm;
  logic [63:0] wd;

  logic        rsp_valid, rsp_we, trap, undef, dbgm, serrm, irqm, fiqm;
  logic [63:0] rdata;
  logic [1:0]  trap_el;
  logic [5:0]  trap_ec;
  logic [3:0]  daif;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [3:0]  m = 4'hF;

  always #4 clk = ~clk;

  excmask_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_op0_i(op0), .req_op1_i(op1),
    .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2), .req_is_read_i(rd),
    .req_wdata_i(wd), .cur_el_i(el), .feat_i(feat), .el0_host_i(host),
    .uma_en_i(uma), .el2_en_i(e2), .tge_i(tge), .dbg_target_el_i(dtgt),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata), .rsp_rd_we_o(rsp_we),
    .trap_o(trap), .trap_el_o(trap_el), .trap_ec_o(trap_ec), .undef_o(undef),
    .daif_o(daif), .dbg_mask_o(dbgm), .serr_mask_o(serrm), .irq_mask_o(irqm),
    .fiq_mask_o(fiqm)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 read, 2 write, 3 set, 4 clear
  function automatic int kind_of();
    if (!v || op1 != 3'b011 || crn != 4'b0100) return 0;
    if (op0 == 2'b11 && crm == 4'b0010 && op2 == 3'b001) return rd ? 1 : 2;
    if (op0 == 2'b00 && op2 == 3'b110) return 3;
    if (op0 == 2'b00 && op2 == 3'b111) return 4;
    return 0;
  endfunction

  task automatic step(input logic iv, input logic [1:0] iop0, input logic [2:0] iop1,
                      input logic [3:0] icrn, input logic [3:0] icrm, input logic [2:0] iop2,
                      input logic ird, input logic [63:0] iwd, input logic [1:0] iel,
                      input logic ihost, input logic iuma, input logic ie2, input logic itge,
                      input logic ifeat, input logic [1:0] idt);
    int k;
    logic x_und, x_trap, x_ok;
    logic [1:0] x_el;
    logic [63:0] x_rd;
    @(negedge clk);
    v = iv; op0 = iop0; op1 = iop1; crn = icrn; crm = icrm; op2 = iop2; rd = ird;
    wd = iwd; el = iel; host = ihost; uma = iuma; e2 = ie2; tge = itge; feat = ifeat;
    dtgt = idt;
    #1;
    chk("R10 serr", 64'(serrm), 64'(m[2]));
    chk("R10 irq", 64'(irqm), 64'(m[1]));
    chk("R10 fiq", 64'(fiqm), 64'(m[0]));
    chk("R11 dbg", 64'(dbgm), 64'(m[3] && (idt == iel)));
    k = kind_of();
    x_und  = (k != 0) && !ifeat;
    x_trap = (k != 0) && ifeat && iel == 2'd0 && (ihost || !iuma);
    x_el   = x_trap ? ((ie2 && itge) ? 2'd2 : 2'd1) : 2'd0;
    x_ok   = (k != 0) && !x_und && !x_trap;
    x_rd   = (x_ok && k == 1) ? {54'd0, m, 6'd0} : 64'd0;
    if (x_ok) begin
      case (k)
        2: m = iwd[9:6];
        3: m = m | icrm;
        4: m = m & ~icrm;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    chk("R12 rsp_valid", 64'(rsp_valid), 64'(k != 0));
    chk("R2 rdata", rdata, x_rd);
    chk("R9 rd_we", 64'(rsp_we), 64'(x_ok && k == 1));
    chk("R8 undef", 64'(undef), 64'(x_und));
    chk("R7 trap", 64'(trap), 64'(x_trap));
    chk("R7 trap_el", 64'(trap_el), 64'(x_el));
    chk("R7 trap_ec", 64'(trap_ec), x_trap ? 64'h18 : 64'h0);
    chk("R3/R4 masks", 64'(daif), 64'(m));
  endtask

  // helpers: register form, immediate form
  task automatic rf(input logic ird, input logic [63:0] iwd, input logic [1:0] iel,
                    input logic ihost, input logic iuma, input logic ie2, input logic itge,
                    input logic ifeat);
    step(1, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b001, ird, iwd, iel, ihost, iuma, ie2, itge,
         ifeat, iel);
  endtask

  task automatic imf(input logic clr, input logic [3:0] imm, input logic [1:0] iel);
    step(1, 2'b00, 3'b011, 4'b0100, imm, clr ? 3'b111 : 3'b110, 0, 64'd0, iel, 0, 1, 0, 0,
         1, iel);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    v = 0; rd = 0; feat = 1; host = 0; uma = 1; e2 = 0; tge = 0;
    op0 = 0; op1 = 0; op2 = 0; crn = 0; crm = 0; wd = 0; el = 1; dtgt = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset masks", 64'(daif), 64'hF);
    chk("R1 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset masks", 64'(daif), 64'hF);

    // R2 read at reset, R3 write with reserved bits set
    rf(1, 64'd0, 2'd1, 0, 0, 0, 0, 1);
    rf(0, ~64'h3C0, 2'd3, 0, 0, 0, 0, 1);
    rf(0, 64'h280, 2'd2, 0, 0, 0, 0, 1);
    rf(1, 64'd0, 2'd2, 0, 0, 0, 0, 1);
    // R4 set and clear
    imf(0, 4'b0101, 2'd1);
    imf(1, 4'b1100, 2'd1);
    imf(1, 4'b0000, 2'd3);
    // R7 EL0 traps and routing
    rf(0, 64'h3C0, 2'd0, 1, 1, 1, 1, 1);
    rf(0, 64'h3C0, 2'd0, 0, 0, 1, 0, 1);
    rf(1, 64'd0, 2'd0, 0, 0, 0, 1, 1);
    step(1, 2'b00, 3'b011, 4'b0100, 4'hF, 3'b110, 0, 0, 2'd0, 1, 1, 1, 1, 1, 2'd0);
    // EL0 allowed
    rf(0, 64'h100, 2'd0, 0, 1, 1, 1, 1);
    // R8 feature absent
    rf(0, 64'h3C0, 2'd1, 0, 0, 0, 0, 0);
    rf(1, 64'd0, 2'd0, 1, 0, 1, 1, 0);
    // R5 near misses
    step(1, 2'b11, 3'b011, 4'b0100, 4'b0011, 3'b001, 0, 64'h3C0, 2'd1, 0, 1, 0, 0, 1, 2'd1);
    step(1, 2'b00, 3'b011, 4'b0100, 4'hF, 3'b101, 0, 0, 2'd1, 0, 1, 0, 0, 1, 2'd1);
    step(0, 2'b11, 3'b011, 4'b0100, 4'b0010, 3'b001, 0, 64'h3C0, 2'd1, 0, 1, 0, 0, 1, 2'd1);
    // R11 debug target higher
    rf(0, 64'h3C0, 2'd1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 0, 0, 0, 0, 1, 2'd2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0, 0, 1, 2'd3);

    for (int i = 0; i < 3000; i++) begin
      int f;
      logic [1:0] a0; logic [2:0] a1, a2; logic [3:0] cn, cm;
      f = $urandom % 6;
      a0 = $urandom; a1 = $urandom; a2 = $urandom; cn = $urandom; cm = $urandom;
      if (f < 2) begin a0 = 2'b11; a1 = 3'b011; cn = 4'b0100; cm = 4'b0010; a2 = 3'b001; end
      else if (f < 4) begin a0 = 2'b00; a1 = 3'b011; cn = 4'b0100; a2 = (f == 2) ? 3'b110 : 3'b111; end
      else if (f == 4) begin a1 = 3'b011; cn = 4'b0100; end
      step(($urandom % 8) != 0, a0, a1, cn, cm, a2, $urandom, {$urandom, $urandom},
           $urandom, $urandom, ($urandom % 4) != 0, $urandom, $urandom,
           ($urandom % 8) != 0, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule